// File: doc/BRIEF.md
# Programmable Gamma Correction Table

This block applies a loadable gamma curve to a stream of RGB pixels. The pipeline holds one table per colour component. Each component of an incoming pixel is used as the address into its own table, and the stored value replaces it on the output. Software loads the tables through one 32-bit write-only port: a strobe plus a data word that carries all three component values at once.

A build-time parameter selects one of two loading modes.

- **Indexed mode:** 256 entries of 8 bits per component. Every word names the entry it targets.
- **Streamed mode:** 1024 entries of 10 bits per component. Words fill the table in sequence through an internal pointer, and a marker bit restarts the sequence at entry 0.

A run-time enable chooses between applying the table and passing pixels through untouched. Both paths have the same fixed latency, so the enable never disturbs pixel timing.

Top module: `gamma_lut`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and `out_r`, `out_g`, `out_b` are all 0.
- R2: A pixel accepted with `pix_valid` high at clock edge k appears on the outputs at edge k+2, with `out_valid` high. `out_valid` stays low at edge k+1 unless another pixel was accepted at edge k−1.
- R3: In indexed mode (`STREAMED`=0), a write with `wr_en` high stores into entry `wr_data[31:24]`. Red takes `wr_data[23:16]`, green takes `wr_data[15:8]` and blue takes `wr_data[7:0]`.
- R4: With `gamma_on` high, each output component equals the stored field of that component's table, read at the address given by the same component's input value. The three lookups are independent of one another.
- R5: With `gamma_on` low when a pixel is accepted, the pixel leaves the block unchanged, with the same 2-cycle latency as the lookup path.
- R6: In streamed mode (`STREAMED`=1), red takes `wr_data[29:20]`, green takes `wr_data[19:10]` and blue takes `wr_data[9:0]`. A write with `wr_data[31]`=1 stores into entry 0 and sets the write pointer to 1.
- R7: In streamed mode, a write with `wr_data[31]`=0 stores at the current pointer and then increments it. After entry 1023 the pointer wraps to entry 0.
- R8: A pixel accepted on the same edge as a table write to the entry it reads gets the old value. A pixel accepted on the following edge gets the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gamma_on | input | 1 | 1: apply the tables; 0: pass pixels through |
| wr_en | input | 1 | Table write strobe, one word per cycle |
| wr_data | input | 32 | Table write word (layout depends on mode) |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | CW (8 or 10) | Input red |
| pix_g | input | CW | Input green |
| pix_b | input | CW | Input blue |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | CW | Output red |
| out_g | output | CW | Output green |
| out_b | output | CW | Output blue |

## Verification
The bound checker watches three behaviours on every cycle:
- the two-edge delay between `pix_valid` and `out_valid`;
- the exact pass-through of component values while the table is disabled;
- in streamed mode, the movement of the write pointer (a restart lands the next plain write on entry 1, and each plain write follows its predecessor by one).

Only the bench scenarios can show what the tables actually hold. They cover:
- the field positions in the indexed and streamed words;
- the independence of the three component lookups;
- the wrap of the streamed pointer back onto entry 0;
- the old-then-new order when a pixel meets a write to the same entry.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

  // width of the software write word
  localparam int WORD_W = 32;

  // component width for the selected load mode
  function automatic int comp_w(input bit streamed);
    return streamed ? 10 : 8;
  endfunction

  // table depth for the selected load mode
  function automatic int tbl_depth(input bit streamed);
    return 1 << comp_w(streamed);
  endfunction

  // position of the restart marker in a streamed word
  localparam int RESTART_BIT = 31;

  // top byte of an indexed word holds the entry address
  localparam int IDX_LSB = 24;

  // index of each component in the per-component arrays
  typedef enum int {
    C_RED = 0,
    C_GRN = 1,
    C_BLU = 2
  } comp_e;

  localparam int NCOMP = 3;

endpackage

// File: rtl/gamma_wr_decode.sv
module gamma_wr_decode
  import gamma_pkg::*;
#(
  parameter bit STREAMED = 1'b0,
  localparam int CW = comp_w(STREAMED),
  localparam int AW = CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              tbl_we,
  output logic [AW-1:0]     tbl_addr,
  output logic [CW-1:0]     tbl_wr_r,
  output logic [CW-1:0]     tbl_wr_g,
  output logic [CW-1:0]     tbl_wr_b
);

  assign tbl_we = wr_en;

  // the three component fields sit side by side at the bottom of the word
  assign tbl_wr_b = wr_data[CW-1:0];
  assign tbl_wr_g = wr_data[2*CW-1:CW];
  assign tbl_wr_r = wr_data[3*CW-1:2*CW];

  generate
    if (STREAMED) begin : g_stream
      logic [AW-1:0] wptr;
      logic          restart;

      assign restart  = wr_data[RESTART_BIT];
      assign tbl_addr = restart ? '0 : wptr;

      // a restart lands on entry 0, so the next word goes to entry 1;
      // any other word advances the pointer, wrapping at the table size
      always_ff @(posedge clk) begin
        if (rst) begin
          wptr <= '0;
        end else if (wr_en) begin
          if (restart) wptr <= AW'(1);
          else         wptr <= wptr + AW'(1);
        end
      end
    end else begin : g_index
      assign tbl_addr = wr_data[IDX_LSB +: AW];
    end
  endgenerate

endmodule

// File: rtl/gamma_comp_ram.sv
module gamma_comp_ram #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // read-first: a read and a write to the same entry on one edge
  // return the value held before the write
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end

endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_pkg::*;
#(
  parameter bit STREAMED = 1'b0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           gamma_on,
  input  logic                           wr_en,
  input  logic [31:0]                    wr_data,
  input  logic                           pix_valid,
  input  logic [comp_w(STREAMED)-1:0]    pix_r,
  input  logic [comp_w(STREAMED)-1:0]    pix_g,
  input  logic [comp_w(STREAMED)-1:0]    pix_b,
  output logic                           out_valid,
  output logic [comp_w(STREAMED)-1:0]    out_r,
  output logic [comp_w(STREAMED)-1:0]    out_g,
  output logic [comp_w(STREAMED)-1:0]    out_b
);

  localparam int CW = comp_w(STREAMED);
  localparam int AW = CW;

  // write side
  logic          dec_we;
  logic [AW-1:0] dec_addr;
  logic [CW-1:0] dec_r, dec_g, dec_b;

  gamma_wr_decode #(.STREAMED(STREAMED)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .tbl_we   (dec_we),
    .tbl_addr (dec_addr),
    .tbl_wr_r (dec_r),
    .tbl_wr_g (dec_g),
    .tbl_wr_b (dec_b)
  );

  // per-component views
  logic [CW-1:0] wr_comp  [NCOMP];
  logic [CW-1:0] in_comp  [NCOMP];
  logic [CW-1:0] lut_comp [NCOMP];
  logic [CW-1:0] s1_comp  [NCOMP];
  logic [CW-1:0] o_comp   [NCOMP];

  assign wr_comp[C_RED] = dec_r;
  assign wr_comp[C_GRN] = dec_g;
  assign wr_comp[C_BLU] = dec_b;
  assign in_comp[C_RED] = pix_r;
  assign in_comp[C_GRN] = pix_g;
  assign in_comp[C_BLU] = pix_b;

  // stage 1 control: valid and the enable travel with the pixel
  logic s1_valid;
  logic s1_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_on    <= 1'b0;
    end else begin
      s1_valid <= pix_valid;
      if (pix_valid) s1_on <= gamma_on;
    end
  end

  // one table, one raw-pixel register and one output register per component
  genvar c;
  generate
    for (c = 0; c < NCOMP; c++) begin : g_comp
      gamma_comp_ram #(.AW(AW), .DW(CW)) u_ram (
        .clk   (clk),
        .we    (dec_we),
        .waddr (dec_addr),
        .wdata (wr_comp[c]),
        .re    (pix_valid),
        .raddr (in_comp[c]),
        .rdata (lut_comp[c])
      );

      // the raw pixel waits alongside the table read for the bypass path
      always_ff @(posedge clk) begin
        if (rst)            s1_comp[c] <= '0;
        else if (pix_valid) s1_comp[c] <= in_comp[c];
      end

      // stage 2: pick the table value or the raw value
      always_ff @(posedge clk) begin
        if (rst)           o_comp[c] <= '0;
        else if (s1_valid) o_comp[c] <= s1_on ? lut_comp[c] : s1_comp[c];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
  end

  assign out_r = o_comp[C_RED];
  assign out_g = o_comp[C_GRN];
  assign out_b = o_comp[C_BLU];

endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk
  import gamma_pkg::*;
#(
  parameter bit STREAMED = 1'b0,
  localparam int CW = comp_w(STREAMED),
  localparam int AW = CW
) (
  input logic          clk,
  input logic          rst,
  input logic          gamma_on,
  input logic          wr_en,
  input logic [31:0]   wr_data,
  input logic          pix_valid,
  input logic [CW-1:0] pix_r,
  input logic [CW-1:0] pix_g,
  input logic [CW-1:0] pix_b,
  input logic          out_valid,
  input logic [CW-1:0] out_r,
  input logic [CW-1:0] out_g,
  input logic [CW-1:0] out_b,
  input logic [AW-1:0] dec_addr
);

  // set one cycle after reset ends, so $past never reaches into reset
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R2: an accepted pixel shows up two edges later
  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> ##1 out_valid);

  // R2: no pixel accepted means no output valid two edges later
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> ##1 !out_valid);

  // R5: bypass delivers the same components after the same delay
  assert_bypass_exact_R5: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !gamma_on) |=> ##1
      (out_r == $past(pix_r, 2) && out_g == $past(pix_g, 2) && out_b == $past(pix_b, 2)));

  generate
    if (STREAMED) begin : g_stream_chk
      // R6: the plain write right after a restart goes to entry 1
      assert_after_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wr_en && wr_data[31]) && wr_en && !wr_data[31])
          |-> dec_addr == AW'(1));

      // R7: back-to-back plain writes step the address by one, with wrap
      assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wr_en) && wr_en && !wr_data[31])
          |-> dec_addr == AW'($past(dec_addr) + 1'b1));
    end
  endgenerate

endmodule

bind gamma_lut gamma_lut_chk #(.STREAMED(STREAMED)) u_gamma_lut_chk (
  .clk       (clk),
  .rst       (rst),
  .gamma_on  (gamma_on),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .pix_valid (pix_valid),
  .pix_r     (pix_r),
  .pix_g     (pix_g),
  .pix_b     (pix_b),
  .out_valid (out_valid),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b),
  .dec_addr  (dec_addr)
);

// File: tb/gamma_lut_bench.sv
`timescale 1ns/1ps
module gamma_lut_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // indexed instance
  logic        i_on = 1'b1, i_we = 1'b0, i_pv = 1'b0;
  logic [31:0] i_wd = '0;
  logic [7:0]  i_r = '0, i_g = '0, i_b = '0;
  logic        i_ov;
  logic [7:0]  i_or, i_og, i_ob;

  // streamed instance
  logic        s_on = 1'b1, s_we = 1'b0, s_pv = 1'b0;
  logic [31:0] s_wd = '0;
  logic [9:0]  s_r = '0, s_g = '0, s_b = '0;
  logic        s_ov;
  logic [9:0]  s_or, s_og, s_ob;

  gamma_lut #(.STREAMED(1'b0)) u_gamma_lut (
    .clk(clk), .rst(rst), .gamma_on(i_on), .wr_en(i_we), .wr_data(i_wd),
    .pix_valid(i_pv), .pix_r(i_r), .pix_g(i_g), .pix_b(i_b),
    .out_valid(i_ov), .out_r(i_or), .out_g(i_og), .out_b(i_ob));

  gamma_lut #(.STREAMED(1'b1)) u_gamma_lut_strm (
    .clk(clk), .rst(rst), .gamma_on(s_on), .wr_en(s_we), .wr_data(s_wd),
    .pix_valid(s_pv), .pix_r(s_r), .pix_g(s_g), .pix_b(s_b),
    .out_valid(s_ov), .out_r(s_or), .out_g(s_og), .out_b(s_ob));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // ---- indexed helpers ----
  task automatic i_write(input int idx, input int r, input int g, input int b);
    @(negedge clk);
    i_we = 1'b1;
    i_wd = {idx[7:0], r[7:0], g[7:0], b[7:0]};
    @(negedge clk);
    i_we = 1'b0;
  endtask

  task automatic i_pixel(input string req, input int r, input int g, input int b,
                         input int er, input int eg, input int eb);
    @(negedge clk);
    i_pv = 1'b1; i_r = r[7:0]; i_g = g[7:0]; i_b = b[7:0];
    @(negedge clk);
    i_pv = 1'b0;
    chk({req, " R2 valid not yet"}, {31'b0, i_ov}, 32'd0);
    @(negedge clk);
    chk({req, " R2 valid"}, {31'b0, i_ov}, 32'd1);
    chk({req, " red"},   {24'b0, i_or}, er);
    chk({req, " green"}, {24'b0, i_og}, eg);
    chk({req, " blue"},  {24'b0, i_ob}, eb);
  endtask

  // ---- streamed helpers ----
  task automatic s_write(input bit first, input int r, input int g, input int b);
    @(negedge clk);
    s_we = 1'b1;
    s_wd = {first, 1'b0, r[9:0], g[9:0], b[9:0]};
    @(negedge clk);
    s_we = 1'b0;
  endtask

  task automatic s_pixel(input string req, input int r, input int g, input int b,
                         input int er, input int eg, input int eb);
    @(negedge clk);
    s_pv = 1'b1; s_r = r[9:0]; s_g = g[9:0]; s_b = b[9:0];
    @(negedge clk);
    s_pv = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, {31'b0, s_ov}, 32'd1);
    chk({req, " red"},   {22'b0, s_or}, er);
    chk({req, " green"}, {22'b0, s_og}, eg);
    chk({req, " blue"},  {22'b0, s_ob}, eb);
  endtask

  // ---- scenarios ----
  task automatic test_reset_R1();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idx valid", {31'b0, i_ov}, 0);
    chk("R1 idx pixel", {8'b0, i_or, i_og, i_ob}, 0);
    chk("R1 strm valid", {31'b0, s_ov}, 0);
    chk("R1 strm pixel", {2'b0, s_or, s_og, s_ob}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idx valid after release", {31'b0, i_ov}, 0);
    chk("R1 strm valid after release", {31'b0, s_ov}, 0);
  endtask

  task automatic test_indexed_R3_R4();
    for (int k = 0; k < 256; k++) i_write(k, 255 - k, k, k ^ 8'h5A);
    i_pixel("R3 R4 mixed", 10, 200, 255, 245, 200, 8'hA5);
    i_pixel("R3 R4 zero",   0,   0,   0, 255,   0, 8'h5A);
    i_pixel("R4 independent", 77, 3, 128, 178, 3, 128 ^ 8'h5A);
  endtask

  task automatic test_bypass_R5();
    i_on = 1'b0;
    i_pixel("R5 idx bypass", 10, 200, 255, 10, 200, 255);
    i_on = 1'b1;
    s_on = 1'b0;
    s_pixel("R5 strm bypass", 5, 700, 1023, 5, 700, 1023);
    s_on = 1'b1;
  endtask

  task automatic test_same_cycle_R8();
    // entry 10 holds r=245 g=10 b=0x50 before the overwrite
    @(negedge clk);
    i_we = 1'b1; i_wd = {8'd10, 8'h11, 8'h22, 8'h33};
    i_pv = 1'b1; i_r = 8'd10; i_g = 8'd10; i_b = 8'd10;
    @(negedge clk);
    i_we = 1'b0;
    @(negedge clk);
    i_pv = 1'b0;
    chk("R8 same edge gets old red", {24'b0, i_or}, 245);
    chk("R8 same edge gets old blue", {24'b0, i_ob}, 8'h50);
    @(negedge clk);
    chk("R8 next edge valid", {31'b0, i_ov}, 1);
    chk("R8 next edge gets new", {8'b0, i_or, i_og, i_ob}, 32'h112233);
  endtask

  task automatic test_streamed_R6_R7();
    s_write(1'b1, 0, 1023, 0);
    for (int k = 1; k < 1024; k++) s_write(1'b0, k, 1023 - k, (k * 3) & 1023);
    // pointer has wrapped: this word overwrites entry 0
    s_write(1'b0, 10'h2AA, 10'h111, 10'h3C3);
    s_pixel("R7 wrap overwrites entry 0", 0, 0, 0, 10'h2AA, 10'h111, 10'h3C3);
    s_pixel("R6 R7 sequence", 5, 700, 1023, 5, 323, 1021);
    s_pixel("R7 entry 1 kept", 1, 1, 1, 1, 1022, 3);
    // restart mid-table: next plain word lands on entry 1
    s_write(1'b0, 7, 7, 7);
    s_write(1'b1, 10'h100, 10'h200, 10'h300);
    s_write(1'b0, 10'h0AB, 10'h0CD, 10'h0EF);
    s_pixel("R6 restart to entry 0", 0, 0, 0, 10'h100, 10'h200, 10'h300);
    s_pixel("R6 after restart entry 1", 1, 1, 1, 10'h0AB, 10'h0CD, 10'h0EF);
  endtask

  initial begin
    test_reset_R1();
    test_indexed_R3_R4();
    test_bypass_R5();
    test_same_cycle_R8();
    test_streamed_R6_R7();
    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule